// File: doc/BRIEF.md
# Switched-Capacitor Cell Switch Sequencer

This block drives the gate controls of a chain of identical capacitor cells. Each cell has five switches; two more switches, one on the input side and one on the output side, are shared by the whole chain. The block alternates a charge phase and a discharge phase at a rate set by a divider. Between the two phases it holds every switch off for a programmable gap, so the phases never overlap. In each phase every cell receives a five-bit switch pattern taken from its active configuration word.

A host writes one ten-bit word per cell into a shadow bank and then issues a commit. The commit is held pending until the chain is inside a gap. At that point all shadow words are copied into the active registers at once, so no cell runs an old pattern beside a new one. A pending flag shows that a commit is still waiting. A sticky error bit records any write aimed at a cell index that does not exist.

The FSM has four states: `ST_CHARGE`, `ST_GAP_C2D`, `ST_DISCHARGE` and `ST_GAP_D2C`. The transitions run CHARGE→GAP_C2D when the charge count expires, GAP_C2D→DISCHARGE when the gap count expires, DISCHARGE→GAP_D2C when the discharge count expires, and GAP_D2C→CHARGE when the gap count expires. Reset enters GAP_D2C.

Top module: `sc_switch_seq`

## Requirements
- R1: `sw_in` is high only in the charge phase and `sw_out` is high only in the discharge phase. The two are never high in the same cycle.
- R2: Each charge phase and each discharge phase lasts exactly `div_len` clocks. A value of 0 is treated as 1.
- R3: Between every two phases there is a gap of `gap_len` clocks, with 0 treated as 1. During the gap `sw_in`, `sw_out` and every `cell_sw` bit are low.
- R4: While reset is asserted, and right after it is released, every switch output is low and `cfg_pending` and `idx_err` are low. The first phase after reset is a charge phase.
- R5: Layout of a configuration word: bits [4:0] are the charge pattern and bits [9:5] are the discharge pattern. Pattern bit k drives switch S(k+1) of the cell, and that switch appears on `cell_sw[5*c+k]` for cell c, with cell 0 first. In the chosen phase each cell outputs exactly its active pattern.
- R6: In the last cell, S2, S3 and S4 (pattern bits 1 to 3) are always low, whatever word is loaded.
- R7: Writes to the shadow bank do not change any output until a commit is applied. A commit updates all cells in the same cycle.
- R8: A commit is applied only inside a gap, so a commit issued during a phase takes effect at the next phase boundary. `cfg_pending` is high from the cycle after the commit until the cycle after the words are copied.
- R9: A write with `ld_idx` ≥ NUM_CELLS changes no shadow word. It sets `idx_err`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_len | input | DIV_W | Phase length in clocks |
| gap_len | input | GAP_W | Gap length in clocks |
| ld_valid | input | 1 | Shadow write strobe |
| ld_idx | input | IDX_W | Target cell index of the write |
| ld_word | input | 10 | Configuration word: discharge pattern [9:5], charge pattern [4:0] |
| commit | input | 1 | Request to transfer the shadow bank to the active registers |
| sw_in | output | 1 | Shared input switch |
| sw_out | output | 1 | Shared output switch |
| cell_sw | output | 5*NUM_CELLS | Per-cell switches S1..S5 |
| cfg_pending | output | 1 | A commit is waiting for a gap |
| idx_err | output | 1 | Sticky flag for an out-of-range index |

## Verification
The bench builds the block with NUM_CELLS=5, DIV_W=8 and GAP_W=4. With five cells the chain has a distinct first, middle and last cell, so the series-link discharge pattern covers all three roles. With IDX_W=3, indices 5 to 7 exist on the port, so out-of-range writes can be driven. The narrow counters make short phase and gap lengths, including the zero-as-one case, cheap to measure in full cycles.

// File: rtl/sc_seq_pkg.sv
package sc_seq_pkg;

    localparam int SW_PER_CELL = 5;
    localparam int CFG_W       = 2 * SW_PER_CELL;

    typedef enum logic [1:0] {
        ST_CHARGE    = 2'd0,
        ST_GAP_C2D   = 2'd1,
        ST_DISCHARGE = 2'd2,
        ST_GAP_D2C   = 2'd3
    } phase_e;

endpackage

// File: rtl/sc_phase_fsm.sv
module sc_phase_fsm
    import sc_seq_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_len,
    input  logic [GAP_W-1:0] gap_len,
    output phase_e           state,
    output logic             in_gap
);

    localparam int CNT_W = (DIV_W > GAP_W) ? DIV_W : GAP_W;

    phase_e           state_q;
    phase_e           state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] div_lim;
    logic [CNT_W-1:0] gap_lim;
    logic [CNT_W-1:0] lim;
    logic             gap_now;
    logic             done;

    // Last count index of each interval; a zero setting counts as one cycle.
    always_comb begin
        div_lim = (div_len == '0) ? '0 : CNT_W'(div_len) - CNT_W'(1);
        gap_lim = (gap_len == '0) ? '0 : CNT_W'(gap_len) - CNT_W'(1);
        gap_now = (state_q == ST_GAP_C2D) || (state_q == ST_GAP_D2C);
        lim     = gap_now ? gap_lim : div_lim;
        done    = (cnt_q >= lim);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CHARGE:    if (done) state_d = ST_GAP_C2D;
            ST_GAP_C2D:   if (done) state_d = ST_DISCHARGE;
            ST_DISCHARGE: if (done) state_d = ST_GAP_D2C;
            ST_GAP_D2C:   if (done) state_d = ST_CHARGE;
            default:      state_d = ST_GAP_D2C;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_GAP_D2C;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_d != state_q) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign state  = state_q;
    assign in_gap = gap_now;

endmodule

// File: rtl/sc_shadow_bank.sv
module sc_shadow_bank
    import sc_seq_pkg::*;
#(
    parameter int NUM_CELLS = 4,
    parameter int IDX_W     = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ld_valid,
    input  logic [IDX_W-1:0]           ld_idx,
    input  logic [CFG_W-1:0]           ld_word,
    input  logic                       commit,
    input  logic                       apply,
    output logic [NUM_CELLS*CFG_W-1:0] shadow,
    output logic                       pending,
    output logic                       idx_err
);

    logic bad_idx;
    logic pend_q;
    logic err_q;

    assign bad_idx = ld_valid && (int'(ld_idx) >= NUM_CELLS);

    for (genvar c = 0; c < NUM_CELLS; c++) begin : g_slot
        logic [CFG_W-1:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (ld_valid && (int'(ld_idx) == c)) begin
                word_q <= ld_word;
            end
        end
        assign shadow[c*CFG_W +: CFG_W] = word_q;
    end

    // A new commit wins over the clear, so a late request is never lost.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (commit) begin
            pend_q <= 1'b1;
        end else if (apply) begin
            pend_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (bad_idx) begin
            err_q <= 1'b1;
        end
    end

    assign pending = pend_q;
    assign idx_err = err_q;

endmodule

// File: rtl/sc_cell_slot.sv
module sc_cell_slot
    import sc_seq_pkg::*;
#(
    parameter bit LAST = 1'b0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   apply,
    input  logic [CFG_W-1:0]       shadow_word,
    input  logic                   sel_dis,
    input  logic                   drive_en,
    output logic [SW_PER_CELL-1:0] sw
);

    logic [CFG_W-1:0]       active_q;
    logic [SW_PER_CELL-1:0] pat;
    logic [SW_PER_CELL-1:0] keep;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= '0;
        end else if (apply) begin
            active_q <= shadow_word;
        end
    end

    // The tail cell has no successor: its parallel and series links stay open.
    if (LAST) begin : g_tail
        assign keep = 5'b10001;
    end else begin : g_body
        assign keep = 5'b11111;
    end

    always_comb begin
        pat = sel_dis ? active_q[CFG_W-1:SW_PER_CELL] : active_q[SW_PER_CELL-1:0];
        sw  = drive_en ? (pat & keep) : '0;
    end

endmodule

// File: rtl/sc_switch_seq.sv
module sc_switch_seq
    import sc_seq_pkg::*;
#(
    parameter int NUM_CELLS = 4,
    parameter int DIV_W     = 16,
    parameter int GAP_W     = 8,
    localparam int IDX_W    = $clog2(NUM_CELLS + 1),
    localparam int SW_W     = SW_PER_CELL * NUM_CELLS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_len,
    input  logic [GAP_W-1:0] gap_len,
    input  logic             ld_valid,
    input  logic [IDX_W-1:0] ld_idx,
    input  logic [CFG_W-1:0] ld_word,
    input  logic             commit,
    output logic             sw_in,
    output logic             sw_out,
    output logic [SW_W-1:0]  cell_sw,
    output logic             cfg_pending,
    output logic             idx_err
);

    phase_e                     state;
    logic                       in_gap;
    logic                       apply;
    logic                       drive_en;
    logic                       sel_dis;
    logic [NUM_CELLS*CFG_W-1:0] shadow;

    sc_phase_fsm #(
        .DIV_W (DIV_W),
        .GAP_W (GAP_W)
    ) fsm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_len (div_len),
        .gap_len (gap_len),
        .state   (state),
        .in_gap  (in_gap)
    );

    sc_shadow_bank #(
        .NUM_CELLS (NUM_CELLS),
        .IDX_W     (IDX_W)
    ) bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_valid (ld_valid),
        .ld_idx   (ld_idx),
        .ld_word  (ld_word),
        .commit   (commit),
        .apply    (apply),
        .shadow   (shadow),
        .pending  (cfg_pending),
        .idx_err  (idx_err)
    );

    // Transfer only while every switch is open.
    assign apply = in_gap && cfg_pending;

    always_comb begin
        sw_in    = 1'b0;
        sw_out   = 1'b0;
        drive_en = 1'b0;
        sel_dis  = 1'b0;
        unique case (state)
            ST_CHARGE: begin
                sw_in    = 1'b1;
                drive_en = 1'b1;
            end
            ST_DISCHARGE: begin
                sw_out   = 1'b1;
                drive_en = 1'b1;
                sel_dis  = 1'b1;
            end
            ST_GAP_C2D, ST_GAP_D2C: begin
                drive_en = 1'b0;
            end
            default: begin
                drive_en = 1'b0;
            end
        endcase
    end

    for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
        sc_cell_slot #(
            .LAST (c == NUM_CELLS - 1)
        ) slot_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .apply       (apply),
            .shadow_word (shadow[c*CFG_W +: CFG_W]),
            .sel_dis     (sel_dis),
            .drive_en    (drive_en),
            .sw          (cell_sw[c*SW_PER_CELL +: SW_PER_CELL])
        );
    end

endmodule

// File: rtl/sc_switch_seq_chk.sv
module sc_switch_seq_chk #(
    parameter int NUM_CELLS = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       sw_in,
    input logic                       sw_out,
    input logic [5*NUM_CELLS-1:0]     cell_sw,
    input logic                       cfg_pending,
    input logic                       idx_err
);

    AST_IN_OUT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_in && sw_out)); // R1

    AST_GAP_ALL_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_in && !sw_out) |-> (cell_sw == '0)); // R3

    AST_TAIL_LINKS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        cell_sw[5*(NUM_CELLS-1)+1 +: 3] == 3'b000); // R6

    AST_CHARGE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        sw_in |=> (!sw_in || $stable(cell_sw))); // R7

    AST_DISCHARGE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        sw_out |=> (!sw_out || $stable(cell_sw))); // R7

    AST_APPLY_IN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_pending) |-> $past(!sw_in && !sw_out)); // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        idx_err |=> idx_err); // R9

endmodule

bind sc_switch_seq sc_switch_seq_chk #(
    .NUM_CELLS (NUM_CELLS)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_in       (sw_in),
    .sw_out      (sw_out),
    .cell_sw     (cell_sw),
    .cfg_pending (cfg_pending),
    .idx_err     (idx_err)
);

// File: tb/sc_switch_seq_tb_top.sv
module sc_switch_seq_tb_top;

    localparam int N     = 5;
    localparam int DIV_W = 8;
    localparam int GAP_W = 4;
    localparam int IDX_W = $clog2(N + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DIV_W-1:0] div_len = 8'd4;
    logic [GAP_W-1:0] gap_len = 4'd2;
    logic             ld_valid = 1'b0;
    logic [IDX_W-1:0] ld_idx = '0;
    logic [9:0]       ld_word = '0;
    logic             commit = 1'b0;
    logic             sw_in;
    logic             sw_out;
    logic [5*N-1:0]   cell_sw;
    logic             cfg_pending;
    logic             idx_err;

    int checks = 0;
    int errors = 0;
    logic [9:0] shadow_m [N];
    logic [9:0] active_m [N];

    always #4 clk = ~clk;

    sc_switch_seq #(.NUM_CELLS(N), .DIV_W(DIV_W), .GAP_W(GAP_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .div_len(div_len), .gap_len(gap_len),
        .ld_valid(ld_valid), .ld_idx(ld_idx), .ld_word(ld_word), .commit(commit),
        .sw_in(sw_in), .sw_out(sw_out), .cell_sw(cell_sw),
        .cfg_pending(cfg_pending), .idx_err(idx_err)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] pat(input logic [9:0] w, input bit dis, input bit last);
        logic [4:0] p;
        p = dis ? w[9:5] : w[4:0];
        if (last) p = p & 5'b10001;
        return p;
    endfunction

    function automatic logic [5*N-1:0] expect_sw(input bit dis);
        logic [5*N-1:0] e;
        for (int c = 0; c < N; c++) e[5*c +: 5] = pat(active_m[c], dis, c == N - 1);
        return e;
    endfunction

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic load(input int idx, input logic [9:0] w);
        @(negedge clk);
        ld_valid = 1'b1; ld_idx = IDX_W'(idx); ld_word = w;
        @(negedge clk);
        ld_valid = 1'b0;
        if (idx < N) shadow_m[idx] = w;
    endtask

    task automatic do_commit();
        @(negedge clk);
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
    endtask

    task automatic wait_charge();
        while (sw_in) @(negedge clk);
        while (!sw_in) @(negedge clk);
    endtask

    task automatic wait_discharge();
        while (sw_out) @(negedge clk);
        while (!sw_out) @(negedge clk);
    endtask

    task automatic commit_and_settle();
        do_commit();
        check(cfg_pending == 1'b1, "R8 pending after commit", 32'(cfg_pending), 1);
        while (cfg_pending) @(negedge clk);
        for (int c = 0; c < N; c++) active_m[c] = shadow_m[c];
    endtask

    task automatic check_both_phases(input string req);
        wait_charge();
        check(cell_sw == expect_sw(1'b0), {req, " charge"}, 32'(cell_sw), 32'(expect_sw(1'b0)));
        wait_discharge();
        check(cell_sw == expect_sw(1'b1), {req, " discharge"}, 32'(cell_sw), 32'(expect_sw(1'b1)));
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check({sw_in, sw_out, cell_sw} == '0, "R4 off in reset", 32'(cell_sw), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({sw_in, sw_out, cell_sw} == '0, "R4 off after reset", 32'(cell_sw), 0);
        check(!cfg_pending && !idx_err, "R4 flags clear", 32'({cfg_pending, idx_err}), 0);
        while (!sw_in && !sw_out) @(negedge clk);
        check(sw_in && !sw_out, "R4 first phase charge", 32'({sw_in, sw_out}), 2);
    endtask

    task automatic t_series_chain();
        load(0, {5'b00101, 5'b10001});
        for (int c = 1; c < N - 1; c++) load(c, {5'b00100, 5'b10001});
        load(N - 1, {5'b10000, 5'b10001});
        commit_and_settle();
        check_both_phases("R5");
    endtask

    task automatic t_timing(input int dv, input int gp);
        int run;
        int exp_div;
        int exp_gap;
        exp_div = (dv == 0) ? 1 : dv;
        exp_gap = (gp == 0) ? 1 : gp;
        @(negedge clk);
        div_len = DIV_W'(dv); gap_len = GAP_W'(gp);
        wait_charge();
        run = 0;
        while (sw_in) begin
            if (sw_out) check(0, "R1 overlap", 1, 0);
            run++; @(negedge clk);
        end
        check(run == exp_div, "R2 charge length", run, exp_div);
        run = 0;
        while (!sw_in && !sw_out) begin
            if (cell_sw != '0) check(0, "R3 cell on in gap", 32'(cell_sw), 0);
            run++; @(negedge clk);
        end
        check(run == exp_gap, "R3 gap length", run, exp_gap);
        check(sw_out && !sw_in, "R1 discharge after gap", 32'({sw_in, sw_out}), 1);
        run = 0;
        while (sw_out) begin
            if (sw_in) check(0, "R1 overlap", 1, 0);
            run++; @(negedge clk);
        end
        check(run == exp_div, "R2 discharge length", run, exp_div);
    endtask

    task automatic t_tail_forced();
        load(N - 1, 10'h3FF);
        commit_and_settle();
        wait_charge();
        check(cell_sw[5*(N-1) +: 5] == 5'b10001, "R6 tail charge", 32'(cell_sw[5*(N-1) +: 5]), 5'h11);
        wait_discharge();
        check(cell_sw[5*(N-1) +: 5] == 5'b10001, "R6 tail discharge", 32'(cell_sw[5*(N-1) +: 5]), 5'h11);
    endtask

    task automatic t_no_commit();
        load(1, 10'h3FF);
        check_both_phases("R7 shadow only");
        commit_and_settle();
        check_both_phases("R7 after commit");
    endtask

    task automatic t_midphase();
        logic [5*N-1:0] old_chg;
        @(negedge clk);
        div_len = 8'd10; gap_len = 4'd2;
        wait_charge();
        old_chg = expect_sw(1'b0);
        load(0, {5'b01010, 5'b00011});
        do_commit();
        check(cfg_pending == 1'b1, "R8 pending mid-phase", 32'(cfg_pending), 1);
        check(cell_sw == old_chg, "R8 old pattern held", 32'(cell_sw), 32'(old_chg));
        for (int c = 0; c < N; c++) active_m[c] = shadow_m[c];
        wait_discharge();
        check(!cfg_pending, "R8 applied at boundary", 32'(cfg_pending), 0);
        check(cell_sw == expect_sw(1'b1), "R8 new discharge", 32'(cell_sw), 32'(expect_sw(1'b1)));
        wait_charge();
        check(cell_sw == expect_sw(1'b0), "R8 new charge", 32'(cell_sw), 32'(expect_sw(1'b0)));
    endtask

    task automatic t_bad_index();
        load(6, 10'h3FF);
        check(idx_err == 1'b1, "R9 error set", 32'(idx_err), 1);
        commit_and_settle();
        check_both_phases("R9 no cell written");
        repeat (20) @(negedge clk);
        check(idx_err == 1'b1, "R9 error sticky", 32'(idx_err), 1);
    endtask

    initial begin
        for (int c = 0; c < N; c++) begin
            shadow_m[c] = '0;
            active_m[c] = '0;
        end
        t_reset();
        t_series_chain();
        t_timing(4, 2);
        t_timing(3, 0);
        t_timing(0, 1);
        @(negedge clk);
        div_len = 8'd4; gap_len = 4'd2;
        t_tail_forced();
        t_no_commit();
        t_midphase();
        t_bad_index();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule